// File: doc/BRIEF.md
# Half-Duplex Line Driver Direction Sequencer

This block steers the driver-enable pin of a two-wire half-duplex transceiver around the transmit side of a serial port. When the transmit queue reports pending characters, the sequencer turns the line driver on. It then waits a programmed number of bit intervals before it lets the transmit shifter send its first start bit. While the permit is active the shifter sends back to back. Once the queue is empty and the last stop bit has left, the driver stays on for a programmed number of bit intervals and is then released.

Because the local receiver hears its own transmission on a shared pair, the block also drives a receive-gate signal. This signal tells the receive path to throw away anything it samples for the whole time the driver is enabled, including the trailing hold period. Both delays are counted in ticks of the bit-rate strobe, so they scale with the configured baud rate. A code of 0 adds no delay. If new data arrives during the trailing hold, transmission resumes at once and the setup delay is not repeated.

Top module: `hdx_dir_seq`

## Requirements
- R1: After reset, `drv_en`, `tx_go` and `rx_block` are all low.
- R2: While idle, a high `txq_nonempty` sampled on a clock edge makes `drv_en` high from the following cycle on.
- R3: With a setup code N greater than 0 latched when the driver turns on, `tx_go` stays low until the N-th `bit_tick` seen after `drv_en` rose. It goes high the cycle after that tick. With N = 0, `tx_go` rises in the same cycle as `drv_en`.
- R4: `tx_go` is only ever high while `drv_en` is high.
- R5: A `tx_done` pulse that arrives while `tx_go` is high and `txq_nonempty` is low drops `tx_go` in the next cycle. `drv_en` then stays high until the H-th later `bit_tick`, where H is the hold code, and goes low the cycle after that tick. With H = 0, `drv_en` goes low in the next cycle.
- R6: If `txq_nonempty` is high during the hold period, `tx_go` goes high in the next cycle with no setup delay.
- R7: `rx_block` is high exactly in the cycles in which `drv_en` is high, the hold period included.
- R8: A `tx_done` pulse while `txq_nonempty` is still high leaves `tx_go` high.
- R9: The largest code, 15 for the default 4-bit fields, gives a delay of 15 bit intervals for both setup and hold.
- R10: Cycles without `bit_tick` do not advance the setup or hold count, however many of them pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle strobe once per bit interval |
| txq_nonempty | input | 1 | Transmit queue holds at least one character |
| tx_done | input | 1 | One-cycle pulse when a character's last stop bit has been sent |
| setup_code | input | CODE_W | Bit intervals between driver enable and the first start bit |
| hold_code | input | CODE_W | Bit intervals the driver stays on after the last stop bit |
| drv_en | output | 1 | Line driver enable |
| tx_go | output | 1 | Permit for the transmit shifter to start characters |
| rx_block | output | 1 | Receive gate; received data is discarded while high |

## Verification
The bench builds the block with the default 4-bit code fields. This brings the full code range into reach, from 0 (no delay) to 15 (the largest delay), for both setup and hold. Directed runs step the bit strobe one tick at a time, with idle cycles in between, to find the exact edge at which each permit and release happens. A long random run then mixes sparse ticks, changing codes, queue refills during hold and back-to-back completions. Each cycle of that run is compared with a requirement-level model of the sequence.

// File: rtl/hdx_dir_seq.sv
module hdx_dir_seq #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              txq_nonempty,
  input  logic              tx_done,
  input  logic [CODE_W-1:0] setup_code,
  input  logic [CODE_W-1:0] hold_code,
  output logic              drv_en,
  output logic              tx_go,
  output logic              rx_block
);

  localparam logic [CODE_W-1:0] ZERO = '0;
  localparam logic [CODE_W-1:0] ONE  = {{(CODE_W-1){1'b0}}, 1'b1};

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_TX, S_HOLD} st_t;

  st_t               st, st_nx;
  logic [CODE_W-1:0] cnt, cnt_nx;

  wire last_tick = bit_tick && (cnt == ONE);

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    case (st)
      S_IDLE:
        if (txq_nonempty) begin
          cnt_nx = setup_code;
          st_nx  = (setup_code == ZERO) ? S_TX : S_SETUP;
        end
      S_SETUP:
        if (bit_tick) begin
          cnt_nx = cnt - ONE;
          if (cnt == ONE) st_nx = S_TX;
        end
      S_TX:
        if (tx_done && !txq_nonempty) begin
          cnt_nx = hold_code;
          st_nx  = (hold_code == ZERO) ? S_IDLE : S_HOLD;
        end
      S_HOLD:
        if (txq_nonempty) st_nx = S_TX;
        else if (bit_tick) begin
          cnt_nx = cnt - ONE;
          if (cnt == ONE) st_nx = S_IDLE;
        end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= ZERO;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
    end
  end

  assign drv_en   = (st != S_IDLE);
  assign tx_go    = (st == S_TX);
  assign rx_block = (st != S_IDLE);

  // R2
  idle_to_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && txq_nonempty) |=> drv_en);

  // R3
  setup_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETUP && !last_tick) |=> !tx_go);

  // R10
  setup_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_SETUP || (st == S_HOLD && !txq_nonempty)) && !bit_tick) |=> $stable(cnt));

  // R5
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_go && tx_done && !txq_nonempty && hold_code == ZERO) |=> !drv_en);

  // R6
  hold_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && txq_nonempty) |=> tx_go);

  // R8
  busy_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_go && tx_done && txq_nonempty) |=> tx_go);

endmodule

// File: tb/test_hdx_dir_seq.sv
module test_hdx_dir_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, txq_nonempty = 1'b0, tx_done = 1'b0;
  logic [3:0] setup_code = 4'd0, hold_code = 4'd0;
  logic drv_en, tx_go, rx_block;

  int total = 0, bad = 0, cyc = 0;
  int m = 0, mc = 0;   // model phase: 0 idle, 1 setup, 2 tx, 3 hold
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  hdx_dir_seq #(.CODE_W(4)) i_hdx_dir_seq (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .txq_nonempty(txq_nonempty),
    .tx_done(tx_done), .setup_code(setup_code), .hold_code(hold_code),
    .drv_en(drv_en), .tx_go(tx_go), .rx_block(rx_block));

  function automatic bit exp_drv(int ph); return ph != 0; endfunction
  function automatic bit exp_go(int ph);  return ph == 2; endfunction

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m = 0; mc = 0; end
    else case (m)
      0: if (txq_nonempty) begin mc = setup_code; m = (setup_code == 0) ? 2 : 1; end
      1: if (bit_tick) begin mc--; if (mc == 0) m = 2; end
      2: if (tx_done && !txq_nonempty) begin mc = hold_code; m = (hold_code == 0) ? 0 : 3; end
      default: if (txq_nonempty) m = 2;
               else if (bit_tick) begin mc--; if (mc == 0) m = 0; end
    endcase
  end

  always @(negedge clk) if (cmp_on && rst_n) begin
    chk("R4", tx_go & ~drv_en, 1'b0);
    chk("R7", rx_block, exp_drv(m));
    chk("R3/R5", drv_en, exp_drv(m));
    chk("R6/R8", tx_go, exp_go(m));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog cycle limit");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic ticks_until(string req, int n, bit watch_go);
    for (int k = 1; k <= n; k++) begin
      bit_tick = 1'b1; step();
      bit_tick = 1'b0;
      if (watch_go) chk(req, tx_go, (k == n));
      else          chk(req, drv_en, (k < n));
      repeat (2) begin
        step();
        if (watch_go) chk(req, tx_go, (k == n));
        else          chk(req, drv_en, (k < n));
      end
    end
  endtask

  task automatic run_setup(int n);
    setup_code = 4'(n); txq_nonempty = 1'b1; step();
    chk("R2", drv_en, 1'b1);
    chk("R3", tx_go, (n == 0));
    if (n > 0) begin
      repeat (10) step();
      chk("R10", tx_go, 1'b0);
      ticks_until("R3", n, 1'b1);
    end
  endtask

  task automatic finish_tx(int h);
    hold_code = 4'(h); txq_nonempty = 1'b0; tx_done = 1'b1; step();
    tx_done = 1'b0;
    chk("R5", tx_go, 1'b0);
    chk("R5", drv_en, (h > 0));
    if (h > 0) begin
      repeat (7) step();
      chk("R10", drv_en, 1'b1);
      ticks_until("R5", h, 1'b0);
    end
    chk("R7", rx_block, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    chk("R1", drv_en, 1'b0); chk("R1", tx_go, 1'b0); chk("R1", rx_block, 1'b0);
    step(); rst_n = 1'b1; step();
    chk("R1", drv_en, 1'b0);
    cmp_on = 1'b1;

    run_setup(0); finish_tx(0);
    run_setup(3); finish_tx(2);
    run_setup(15); finish_tx(15);   // R9
    run_setup(1);
    txq_nonempty = 1'b1; tx_done = 1'b1; step(); tx_done = 1'b0;
    chk("R8", tx_go, 1'b1);
    hold_code = 4'd9; txq_nonempty = 1'b0; tx_done = 1'b1; step(); tx_done = 1'b0;
    bit_tick = 1'b1; step(); bit_tick = 1'b0; step();
    chk("R5", drv_en, 1'b1); chk("R6", tx_go, 1'b0);
    txq_nonempty = 1'b1; step();
    chk("R6", tx_go, 1'b1);
    finish_tx(1);

    for (int i = 0; i < 6000; i++) begin
      bit_tick = ($urandom % 3) == 0;
      if (($urandom % 8) == 0) txq_nonempty = ~txq_nonempty;
      tx_done = tx_go && (($urandom % 4) == 0);
      if (($urandom % 50) == 0) setup_code = 4'($urandom);
      if (($urandom % 50) == 0) hold_code = 4'($urandom);
      step();
    end
    bit_tick = 1'b0; tx_done = 1'b0; txq_nonempty = 1'b0;
    step();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule